// File: doc/BRIEF.md
# Parallel Printer Port Host Registers

This block is the host-facing register set of a byte-wide parallel printer port with a built-in printer emulation. The host reaches it over a simple synchronous bus: a write or read strobe, an address of which only the low three bits are decoded, and byte data. There are three registers: a data register at offset 0, a status register at offset 1 and a control register at offset 2.

No external printer is needed. Host writes to the control register and host reads of the status register drive the busy and acknowledge bits, as a printer answering the strobe handshake would. When the host completes a strobe pulse, the current output byte is printed: it appears on `prn_byte` with a one-cycle `prn_valid` pulse. A strobe pulse made with interrupts enabled raises a pending interrupt, which the host clears by reading status. An input latch, loaded from outside, lets the host read a byte back when the direction bit selects input.

Top module: `pport_host_regs`

## Requirements
- R1: Only `bus_addr[2:0]` is decoded. Offset 0 is data, 1 is status and 2 is control. Offsets 3 to 7 read as 0xFF, and writes to them have no effect.
- R2: After reset, a data read returns 0xFF, status reads 0xD9, control reads 0xCC, and `irq` and `prn_valid` are 0.
- R3: Control bits 7:6 are always stored and read back as 1. Control bit 5 is direction (1 = input), bit 4 is interrupt enable, bit 3 is select, bit 2 is init and bit 0 is strobe.
- R4: A data write loads the output latch. A pulse on `in_load` loads `in_byte` into the input latch. A data read returns the input latch when control bit 5 is 1, and the output latch otherwise.
- R5: A control write with bit 2 (init) at 0 sets status to 0xD8.
- R6: A control write with init, select and strobe all at 1 clears status bit 7 (busy) and leaves the other status bits unchanged.
- R7: When the write in R6 finds the stored strobe bit at 0, `prn_valid` is high for exactly one cycle after that write, with `prn_byte` equal to the output latch. Otherwise no byte is emitted.
- R8: A control write with init and select at 1 and strobe at 0 sets interrupt pending only if the previously stored control has bit 4 set.
- R9: A status read returns the status held before the read and clears interrupt pending.
- R10: A status read made while status bit 7 is 0 and the stored strobe bit is 0 advances the handshake. If bit 6 (acknowledge) is 1, the read clears it. If bit 6 is 0, the read sets bits 7 and 6.
- R11: `irq` is a registered copy of interrupt pending and follows it one clock later.
- R12: When `bus_wr` and `bus_rd` are high in the same cycle, only the write takes effect, and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | ADDR_W | Host address; low 3 bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| in_load | input | 1 | Loads the input latch |
| in_byte | input | 8 | Byte for the input latch |
| irq | output | 1 | Interrupt request |
| prn_valid | output | 1 | One-cycle pulse per printed byte |
| prn_byte | output | 8 | Printed byte |

## Verification
The bench builds the block with the default `ADDR_W` of 8. This puts bits above the decoded three within reach, so an aliased control address can show that those bits are masked. The full handshake is walked through: strobe release, acknowledge clear, acknowledge-and-busy set. Interrupts are raised once with interrupt enable stored and once with it still clear. The write/read collision is also exercised.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STB = 0;
  localparam int C_INI = 2;
  localparam int C_SEL = 3;
  localparam int C_IEN = 4;
  localparam int C_DIR = 5;
  // status bit positions
  localparam int S_ACK = 6;
  localparam int S_BSY = 7;

  localparam logic [BYTE_W-1:0] RST_DATA  = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_STAT  = 8'hD9;
  localparam logic [BYTE_W-1:0] RST_CTRL  = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_INIT = 8'hD8;
  localparam logic [BYTE_W-1:0] UNMAPPED  = 8'hFF;

  // value kept in the control register for a given host write
  function automatic logic [BYTE_W-1:0] ctrl_store(input logic [BYTE_W-1:0] w);
    return w | 8'hC0;
  endfunction

  // status after a host status read
  function automatic logic [BYTE_W-1:0] hs_advance(input logic [BYTE_W-1:0] s,
                                                   input logic [BYTE_W-1:0] c);
    logic [BYTE_W-1:0] r;
    r = s;
    if (!s[S_BSY] && !c[C_STB]) begin
      if (s[S_ACK]) r[S_ACK] = 1'b0;
      else          r = s | 8'hC0;
    end
    return r;
  endfunction
endpackage

// File: rtl/pport_ctrl_status.sv
module pport_ctrl_status
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] control,
  output logic              pending,
  output logic              emit
);
  logic [BYTE_W-1:0] stat_n, ctrl_n, wv;
  logic              pend_n;

  always_comb begin
    stat_n = status;
    ctrl_n = control;
    pend_n = pending;
    emit   = 1'b0;
    wv     = ctrl_store(wdata);
    if (ctrl_wr) begin
      if (!wv[C_INI]) begin
        stat_n = STAT_INIT;
      end else if (wv[C_SEL]) begin
        if (wv[C_STB]) begin
          stat_n[S_BSY] = 1'b0;
          emit          = !control[C_STB];
        end else if (control[C_IEN]) begin
          pend_n = 1'b1;
        end
      end
      ctrl_n = wv;
    end else if (stat_rd) begin
      pend_n = 1'b0;
      stat_n = hs_advance(status, control);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= RST_STAT;
      control <= RST_CTRL;
      pending <= 1'b0;
    end else begin
      status  <= stat_n;
      control <= ctrl_n;
      pending <= pend_n;
    end
  end

  AST_CTRL_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    control[7:6] == 2'b11); // R3
  AST_INIT_LOW_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[C_INI]) |=> (status == STAT_INIT)); // R5
  AST_STROBE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[C_INI] && wdata[C_SEL] && wdata[C_STB]) |=> !status[S_BSY]); // R6
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !pending); // R9
  AST_PEND_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(control[C_IEN])); // R8
endmodule

// File: rtl/pport_data_latch.sv
module pport_data_latch
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              in_load,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_latch,
  output logic [BYTE_W-1:0] in_latch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_latch <= RST_DATA;
      in_latch  <= RST_DATA;
    end else begin
      if (data_wr) out_latch <= wdata;
      if (in_load) in_latch  <= in_byte;
    end
  end

  AST_OUT_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(out_latch)); // R4
endmodule

// File: rtl/pport_read_mux.sv
module pport_read_mux
  import pport_pkg::*;
(
  input  logic [2:0]        ofs,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] control,
  input  logic [BYTE_W-1:0] out_latch,
  input  logic [BYTE_W-1:0] in_latch,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    unique case (ofs)
      OFS_DATA: rdata = control[C_DIR] ? in_latch : out_latch;
      OFS_STAT: rdata = status;
      OFS_CTRL: rdata = control;
      default:  rdata = UNMAPPED;
    endcase
  end
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              in_load,
  input  logic [7:0]        in_byte,
  output logic              irq,
  output logic              prn_valid,
  output logic [7:0]        prn_byte
);
  localparam int DEC_W = 3;

  logic [DEC_W-1:0]  ofs;
  logic              rd_ev, data_wr, ctrl_wr, stat_rd, pending, emit;
  logic [BYTE_W-1:0] status, control, out_latch, in_latch;

  assign ofs     = bus_addr[DEC_W-1:0];
  assign rd_ev   = bus_rd && !bus_wr;
  assign data_wr = bus_wr && (ofs == OFS_DATA);
  assign ctrl_wr = bus_wr && (ofs == OFS_CTRL);
  assign stat_rd = rd_ev  && (ofs == OFS_STAT);

  pport_ctrl_status u_cs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .wdata(bus_wdata), .status(status), .control(control),
    .pending(pending), .emit(emit)
  );

  pport_data_latch u_dl (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata),
    .in_load(in_load), .in_byte(in_byte),
    .out_latch(out_latch), .in_latch(in_latch)
  );

  pport_read_mux u_rm (
    .ofs(ofs), .status(status), .control(control),
    .out_latch(out_latch), .in_latch(in_latch), .rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      prn_valid <= 1'b0;
      prn_byte  <= '0;
    end else begin
      irq       <= pending;
      prn_valid <= emit;
      if (emit) prn_byte <= out_latch;
    end
  end

  AST_PRINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |=> !prn_valid); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |=> irq); // R11
  AST_COLLIDE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd && ofs == OFS_CTRL && pending && !bus_wdata[C_STB] && bus_wdata[C_INI]) |=> pending); // R12
endmodule

// File: tb/pport_host_regs_tb.sv
module pport_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, in_load = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, in_byte = '0;
  logic [7:0] bus_rdata, prn_byte;
  logic       irq, prn_valid;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  pport_host_regs #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_load(in_load), .in_byte(in_byte), .irq(irq),
    .prn_valid(prn_valid), .prn_byte(prn_byte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 irq", {7'd0, irq}, 8'h00);
    chk("R2 prn_valid", {7'd0, prn_valid}, 8'h00);
    rd(8'h00, v); chk("R2 data", v, 8'hFF);
    rd(8'h02, v); chk("R2 control", v, 8'hCC);
    rd(8'h01, v); chk("R2 status", v, 8'hD9);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    for (int a = 3; a < 8; a++) begin
      wr(8'(a), 8'h00);
      rd(8'(a), v); chk("R1 unmapped", v, 8'hFF);
    end
    rd(8'h02, v); chk("R1 unmapped write no effect", v, 8'hCC);
    rd(8'h0A, v); chk("R1 masked addr", v, 8'hCC);
    wr(8'h02, 8'h0C); rd(8'h02, v); chk("R3 top bits", v, 8'hCC);
  endtask

  task automatic t_print();
    logic [7:0] v;
    wr(8'h00, 8'h5A);
    wr(8'h02, 8'h0D);
    chk("R7 pulse", {7'd0, prn_valid}, 8'h01);
    chk("R7 byte", prn_byte, 8'h5A);
    idle(); chk("R7 one cycle", {7'd0, prn_valid}, 8'h00);
    rd(8'h01, v); chk("R6 busy clear", v, 8'h59);
    rd(8'h01, v); chk("R10 no advance strobe high", v, 8'h59);
    wr(8'h02, 8'h0D);
    chk("R7 no repeat", {7'd0, prn_valid}, 8'h00);
    wr(8'h02, 8'h0C);
    rd(8'h01, v); chk("R10 before ack clear", v, 8'h59);
    rd(8'h01, v); chk("R10 ack cleared", v, 8'h19);
    rd(8'h01, v); chk("R10 ack busy set", v, 8'hD9);
    rd(8'h01, v); chk("R10 stable busy", v, 8'hD9);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(8'h02, 8'h1C); idle(); idle();
    chk("R8 no pend without stored ien", {7'd0, irq}, 8'h00);
    wr(8'h02, 8'h1D);
    wr(8'h02, 8'h1C);
    chk("R11 irq lags", {7'd0, irq}, 8'h00);
    idle(); chk("R8 pend set", {7'd0, irq}, 8'h01);
    @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h01; bus_wdata = 8'h00;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    idle(); chk("R12 collide keeps pend", {7'd0, irq}, 8'h01);
    rd(8'h01, v); chk("R9 status value", v, 8'h59);
    chk("R11 irq before clear seen", {7'd0, irq}, 8'h01);
    idle(); chk("R9 pend cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_init_dir();
    logic [7:0] v;
    wr(8'h02, 8'h08);
    rd(8'h02, v); chk("R3 ctrl init low", v, 8'hC8);
    rd(8'h01, v); chk("R5 forced", v, 8'hD8);
    @(negedge clk); in_load = 1'b1; in_byte = 8'h3C;
    @(negedge clk); in_load = 1'b0;
    wr(8'h00, 8'hA5);
    rd(8'h00, v); chk("R4 output latch", v, 8'hA5);
    wr(8'h02, 8'h2C);
    rd(8'h00, v); chk("R4 input latch", v, 8'h3C);
    wr(8'h02, 8'h0C);
    rd(8'h00, v); chk("R4 back to output", v, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_print();
    t_irq();
    t_init_dir();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule